// File: doc/BRIEF.md
# Manchester Bit-Timing Drift Compensator

This block keeps the half-bit timing of a Manchester receiver aligned with the incoming line. It counts ticks of an enable running at sixteen times the half-bit rate. One phase count covers one half-bit period. The point where the count wraps is where the block expects the next line transition. At the half-way count it raises a one-cycle sample strobe and captures the line value, so the decoder behind it always samples at the centre of each half-bit.

When tracking is enabled in sixteen-times mode, each line transition is measured against the expected wrap point. If the transition is a little early, the running period loses one tick. If it is a little late, the period gains one tick. A transition within one tick of the expected point counts as jitter and is ignored, and so is any transition outside the small correction windows. At most one correction is made per period. Each correction is also shown on a one-cycle early or late pulse.

In eight-times mode the period is 8 ticks and the strobe comes at count 4. No correction is made in that mode, and none is made while tracking is disabled.

Top module: `manchester_drift_comp`

## Requirements
- R1: While reset is low and after its release, sample_stb, early_pulse and late_pulse are 0 and the phase count is 0, so the first strobe follows the 9th tick in 16x mode.
- R2: In 16x mode with no line transitions, the period is 16 ticks and sample_stb pulses after the ticks at count 8, which are the 9th, 25th, 41st and 57th ticks after reset.
- R3: In 8x mode (mode_16x = 0), the period is 8 ticks and the strobe follows ticks 5, 13, 21 and 29 after reset.
- R4: When sample_stb is high, sample_val equals the rx_in value present at the strobing tick.
- R5: A transition first seen at count 15, 0 or 1 (one tick or less from the wrap) causes no pulse and leaves the period at 16.
- R6: With tracking active, a transition first seen at count 12, 13 or 14 (two to four ticks early) gives one early_pulse after that tick and makes the current period 15 ticks.
- R7: With tracking active, a transition first seen at count 2 or 3 (two or three ticks late) gives one late_pulse after that tick and makes the current period 17 ticks.
- R8: A transition first seen at counts 4 to 11 causes no pulse and no change of period.
- R9: When drift_en is 0, or in 8x mode, no early or late pulse occurs and the period stays at its nominal length.
- R10: At most one correction is applied per period, so a 16x period is always 15, 16 or 17 ticks long. Corrections in consecutive periods are allowed.
- R11: sample_stb, early_pulse and late_pulse are single-cycle pulses that appear only in the cycle after a tick, and early_pulse and late_pulse are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling enable, one cycle per tick |
| rx_in | input | 1 | Serial line, already synchronised |
| drift_en | input | 1 | Enables timing correction |
| mode_16x | input | 1 | 1 = 16 ticks per half-bit, 0 = 8 |
| sample_stb | output | 1 | Pulse at each half-bit centre |
| sample_val | output | 1 | Line value captured at the strobe |
| early_pulse | output | 1 | Period was shortened by one tick |
| late_pulse | output | 1 | Period was lengthened by one tick |

## Verification
A wrong phase count, or a correction latched into the wrong period, moves every later sample_stb off its expected tick. The shift shows at the next strobe, no more than 17 ticks later. A misclassified offset shows at once: a pulse appears on the wrong one of early_pulse or late_pulse, or is missing, in the cycle after the tick that carries the transition. The period that follows then shifts by one tick.

// File: rtl/mdc_pkg.sv
// Package: shared types for the Manchester drift compensator.
// Assumes: nothing beyond IEEE 1800-2017.
package mdc_pkg;

    // Adjustment held for the period in progress.
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

endpackage

// File: rtl/mdc_edge_tap.sv
// Module: mdc_edge_tap
// Finds line transitions by comparing the current synchronised sample
// with the one taken at the previous tick.
// Assumes: rx_in is already synchronised to clk; the line idles low after reset.
module mdc_edge_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic edge_seen
);

    logic prev_q;

    // Hold the line value seen at the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (tick) begin
            prev_q <= rx_in;
        end
    end

    // A transition is reported only on a tick.
    always_comb begin
        edge_seen = tick && (rx_in != prev_q);
    end

endmodule

// File: rtl/mdc_window.sv
// Module: mdc_window
// Sorts a transition by its phase count into the early window, the late
// window, or neither. Neither covers the dead band and out-of-window edges.
// Assumes: phase is the count before the tick update; the expected
// transition is at count 0.
module mdc_window #(
    parameter int OSR       = 16,
    parameter int DEAD_BAND = 1,
    parameter int EARLY_MAX = 4,
    parameter int LATE_MAX  = 3,
    parameter int CW        = 5
) (
    input  logic [CW-1:0] phase,
    input  logic          edge_seen,
    input  logic          active,
    input  logic          corr_done,
    output logic          want_short,
    output logic          want_long
);

    localparam logic [CW-1:0] LATE_LO  = CW'(DEAD_BAND + 1);
    localparam logic [CW-1:0] LATE_HI  = CW'(LATE_MAX);
    localparam logic [CW-1:0] EARLY_LO = CW'(OSR - EARLY_MAX);
    localparam logic [CW-1:0] EARLY_HI = CW'(OSR - DEAD_BAND - 1);

    logic in_late;
    logic in_early;
    logic may_fix;

    // Map the phase count onto the two correction windows.
    always_comb begin
        in_late  = (phase >= LATE_LO) && (phase <= LATE_HI);
        in_early = (phase >= EARLY_LO) && (phase <= EARLY_HI);
    end

    // Allow a correction only when tracking is on and none is spent yet.
    always_comb begin
        may_fix    = edge_seen && active && !corr_done;
        want_short = may_fix && in_early;
        want_long  = may_fix && in_late && !in_early;
    end

endmodule

// File: rtl/mdc_phase.sv
// Module: mdc_phase
// Phase counter for one half-bit period. The nominal terminal count comes
// from the mode. A correction moves the terminal by one tick for the rest
// of the period, and only one correction is accepted per period.
// Assumes: do_short and do_long are never high together and arrive with tick.
module mdc_phase #(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_16x,
    input  logic          do_short,
    input  logic          do_long,
    output logic [CW-1:0] phase_q,
    output logic          corr_done_q
);

    import mdc_pkg::*;

    localparam logic [CW-1:0] HI_LAST = CW'(OSR_HI - 1);
    localparam logic [CW-1:0] LO_LAST = CW'(OSR_LO - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    adj_e          adj_q;
    adj_e          adj_eff;
    logic [CW-1:0] term;
    logic          at_end;

    // Combine the held adjustment with a correction arriving now.
    always_comb begin
        adj_eff = adj_q;
        if (do_short) begin
            adj_eff = ADJ_SHORT;
        end else if (do_long) begin
            adj_eff = ADJ_LONG;
        end
    end

    // Select the terminal count for the period in progress.
    always_comb begin
        if (!mode_16x) begin
            term = LO_LAST;
        end else begin
            case (adj_eff)
                ADJ_SHORT: term = HI_LAST - ONE;
                ADJ_LONG:  term = HI_LAST + ONE;
                default:   term = HI_LAST;
            endcase
        end
        at_end = (phase_q >= term);
    end

    // Advance the count. At the period end, wrap and clear the adjustment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= '0;
            adj_q       <= ADJ_NONE;
            corr_done_q <= 1'b0;
        end else if (tick) begin
            if (at_end) begin
                phase_q     <= '0;
                adj_q       <= ADJ_NONE;
                corr_done_q <= 1'b0;
            end else begin
                phase_q     <= phase_q + ONE;
                adj_q       <= adj_eff;
                corr_done_q <= corr_done_q || do_short || do_long;
            end
        end
    end

endmodule

// File: rtl/mdc_strobe.sv
// Module: mdc_strobe
// Registers the block outputs: the mid-period sample strobe with its value,
// and the one-cycle correction pulses.
// Assumes: the correction requests are already qualified by tick.
module mdc_strobe #(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_16x,
    input  logic [CW-1:0] phase,
    input  logic          rx_in,
    input  logic          do_short,
    input  logic          do_long,
    output logic          stb_q,
    output logic          val_q,
    output logic          early_q,
    output logic          late_q
);

    localparam logic [CW-1:0] HI_MID = CW'(OSR_HI / 2);
    localparam logic [CW-1:0] LO_MID = CW'(OSR_LO / 2);

    logic at_mid;

    // Find the half-bit centre for the current mode.
    always_comb begin
        at_mid = tick && (phase == (mode_16x ? HI_MID : LO_MID));
    end

    // Register the strobe, the captured line value and the correction pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            val_q   <= 1'b0;
            early_q <= 1'b0;
            late_q  <= 1'b0;
        end else begin
            stb_q   <= at_mid;
            early_q <= do_short;
            late_q  <= do_long;
            if (at_mid) begin
                val_q <= rx_in;
            end
        end
    end

endmodule

// File: rtl/manchester_drift_comp.sv
// Module: manchester_drift_comp (top)
// Keeps half-bit sampling aligned to a Manchester line. Small early or
// late transitions trim the running period by one tick. Correction works
// only in 16x mode with drift_en set.
// Assumes: rx_in is synchronised; tick is a one-cycle enable.
module manchester_drift_comp #(
    parameter int OSR_HI    = 16,
    parameter int OSR_LO    = 8,
    parameter int DEAD_BAND = 1,
    parameter int EARLY_MAX = 4,
    parameter int LATE_MAX  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    input  logic drift_en,
    input  logic mode_16x,
    output logic sample_stb,
    output logic sample_val,
    output logic early_pulse,
    output logic late_pulse
);

    localparam int CW = $clog2(OSR_HI + 2);

    logic          edge_seen;
    logic          active;
    logic          corr_done_q;
    logic          want_short;
    logic          want_long;
    logic [CW-1:0] phase_q;

    // Correction is allowed only in 16x mode with tracking enabled.
    always_comb begin
        active = drift_en && mode_16x;
    end

    mdc_edge_tap u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_in     (rx_in),
        .edge_seen (edge_seen)
    );

    mdc_window #(
        .OSR       (OSR_HI),
        .DEAD_BAND (DEAD_BAND),
        .EARLY_MAX (EARLY_MAX),
        .LATE_MAX  (LATE_MAX),
        .CW        (CW)
    ) u_win (
        .phase      (phase_q),
        .edge_seen  (edge_seen),
        .active     (active),
        .corr_done  (corr_done_q),
        .want_short (want_short),
        .want_long  (want_long)
    );

    mdc_phase #(
        .OSR_HI (OSR_HI),
        .OSR_LO (OSR_LO),
        .CW     (CW)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .mode_16x    (mode_16x),
        .do_short    (want_short),
        .do_long     (want_long),
        .phase_q     (phase_q),
        .corr_done_q (corr_done_q)
    );

    mdc_strobe #(
        .OSR_HI (OSR_HI),
        .OSR_LO (OSR_LO),
        .CW     (CW)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_16x (mode_16x),
        .phase    (phase_q),
        .rx_in    (rx_in),
        .do_short (want_short),
        .do_long  (want_long),
        .stb_q    (sample_stb),
        .val_q    (sample_val),
        .early_q  (early_pulse),
        .late_q   (late_pulse)
    );

endmodule

// File: rtl/mdc_checker.sv
// Module: mdc_checker
// Timing properties of the drift compensator, attached to the top by bind.
// Assumes: the phase count of the top is connected to the phase input.
module mdc_checker #(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8,
    parameter int CW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          rx_in,
    input logic          drift_en,
    input logic          mode_16x,
    input logic          sample_stb,
    input logic          sample_val,
    input logic          early_pulse,
    input logic          late_pulse,
    input logic [CW-1:0] phase
);

    localparam logic [CW-1:0] HI_MID = CW'(OSR_HI / 2);
    localparam logic [CW-1:0] LO_MID = CW'(OSR_LO / 2);
    localparam logic [CW-1:0] P_MAX  = CW'(OSR_HI);
    localparam logic [CW-1:0] P_MIN  = CW'(OSR_HI - 2);

    logic [CW-1:0] last_phase;
    logic          corr_seen;
    logic          wrap_now;

    always_comb begin
        wrap_now = (phase == '0) && (last_phase != '0);
    end

    // Track the period boundary and whether a correction has already been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_phase <= '0;
            corr_seen  <= 1'b0;
        end else begin
            last_phase <= phase;
            if (wrap_now) begin
                corr_seen <= 1'b0;
            end else if (early_pulse || late_pulse) begin
                corr_seen <= 1'b1;
            end
        end
    end

    p_no_fix_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(drift_en && mode_16x)) |=> (!early_pulse && !late_pulse));

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(early_pulse && late_pulse));

    p_pulse_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || early_pulse || late_pulse) |-> $past(tick));

    p_one_fix_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (early_pulse || late_pulse) |-> !corr_seen);

    p_stb_centre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ($past(phase) == ($past(mode_16x) ? HI_MID : LO_MID)));

    p_sample_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sample_val == $past(rx_in)));

    p_period_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 && $past(tick) && $past(rst_n)) |->
        ($past(phase) <= P_MAX && ($past(phase) >= P_MIN || !$past(mode_16x))));

endmodule

bind manchester_drift_comp mdc_checker #(
    .OSR_HI (OSR_HI),
    .OSR_LO (OSR_LO),
    .CW     (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rx_in       (rx_in),
    .drift_en    (drift_en),
    .mode_16x    (mode_16x),
    .sample_stb  (sample_stb),
    .sample_val  (sample_val),
    .early_pulse (early_pulse),
    .late_pulse  (late_pulse),
    .phase       (phase_q)
);

// File: tb/sim_manchester_drift_comp.sv
module sim_manchester_drift_comp;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_TICKS  = 60;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic tick;
    logic rx_in;
    logic drift_en;
    logic mode_16x;
    logic sample_stb;
    logic sample_val;
    logic early_pulse;
    logic late_pulse;

    int total  = 0;
    int bad    = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    manchester_drift_comp u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rx_in       (rx_in),
        .drift_en    (drift_en),
        .mode_16x    (mode_16x),
        .sample_stb  (sample_stb),
        .sample_val  (sample_val),
        .early_pulse (early_pulse),
        .late_pulse  (late_pulse)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1: reset clears the outputs and the phase.
    task automatic do_reset(input logic m16, input logic en);
        @(negedge clk);
        rst_n    = 1'b0;
        tick     = 1'b0;
        rx_in    = 1'b0;
        mode_16x = m16;
        drift_en = en;
        repeat (2) @(negedge clk);
        chk("R1", "stb in reset", int'(sample_stb), 0);
        chk("R1", "pulses in reset", int'(early_pulse | late_pulse), 0);
        rst_n = 1'b1;
    endtask

    // Runs RUN_TICKS ticks with up to two line toggles at ticks t1 and t2
    // (0 means no toggle), then compares strobe ticks and pulse ticks.
    task automatic run_case(input string req, input logic m16, input logic en,
                            input int t1, input int t2,
                            input int s0, input int s1, input int s2, input int s3,
                            input int e_tick, input int l_tick);
        int stb_at[4];
        int ns = 0;
        int ne = 0;
        int nl = 0;
        int e_at = 0;
        int l_at = 0;
        int stuck = 0;
        int val_bad = 0;
        logic lvl;
        for (int k = 0; k < 4; k++) stb_at[k] = 0;
        do_reset(m16, en);
        for (int n = 1; n <= RUN_TICKS; n++) begin
            lvl = ((t1 != 0) && (n >= t1)) ^ ((t2 != 0) && (n >= t2));
            rx_in = lvl;
            tick  = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (sample_stb) begin
                if (ns < 4) stb_at[ns] = n;
                ns++;
                if (sample_val != lvl) val_bad++;
            end
            if (early_pulse) begin
                if (ne == 0) e_at = n;
                ne++;
            end
            if (late_pulse) begin
                if (nl == 0) l_at = n;
                nl++;
            end
            @(negedge clk);
            if (sample_stb || early_pulse || late_pulse) stuck++;
        end
        chk(m16 ? "R2" : "R3", {req, " strobe 1"}, stb_at[0], s0);
        chk(m16 ? "R2" : "R3", {req, " strobe 2"}, stb_at[1], s1);
        chk(req, "strobe 3", stb_at[2], s2);
        chk(req, "strobe 4", stb_at[3], s3);
        chk("R4", {req, " sample values wrong"}, val_bad, 0);
        chk(req, "early count", ne, (e_tick != 0) ? 1 : 0);
        chk(req, "early tick", e_at, e_tick);
        chk(req, "late count", nl, (l_tick != 0) ? 1 : 0);
        chk(req, "late tick", l_at, l_tick);
        chk("R11", {req, " pulse held past one cycle"}, stuck, 0);
    endtask

    initial begin
        rst_n    = 1'b0;
        tick     = 1'b0;
        rx_in    = 1'b0;
        drift_en = 1'b0;
        mode_16x = 1'b1;

        // R1 R2: quiet line, nominal 16-tick periods.
        run_case("R2", 1'b1, 1'b1, 0, 0, 9, 25, 41, 57, 0, 0);

        // R5 R6 R7 R8: one transition at every count of the second period.
        for (int c = 0; c < 16; c++) begin
            int adj;
            int et;
            int lt;
            string rq;
            adj = 0; et = 0; lt = 0; rq = "R8";
            if (c == 0 || c == 1 || c == 15) rq = "R5";
            if (c >= 12 && c <= 14) begin adj = -1; et = 17 + c; rq = "R6"; end
            if (c == 2 || c == 3)    begin adj = 1;  lt = 17 + c; rq = "R7"; end
            run_case(rq, 1'b1, 1'b1, 17 + c, 0, 9, 25, 41 + adj, 57 + adj, et, lt);
        end

        // R9: tracking disabled in 16x mode, transitions in both windows.
        for (int i = 0; i < 5; i++) begin
            int c;
            c = (i < 2) ? (2 + i) : (10 + i);
            run_case("R9", 1'b1, 1'b0, 17 + c, 0, 9, 25, 41, 57, 0, 0);
        end

        // R3 R9: 8x mode, enable set, transitions at every count.
        for (int c = 0; c < 8; c++) begin
            run_case("R3", 1'b0, 1'b1, 9 + c, 0, 5, 13, 21, 29, 0, 0);
        end

        // R10: a late fix blocks an early one in the same period.
        run_case("R10", 1'b1, 1'b1, 19, 30, 9, 25, 42, 58, 0, 19);
        // R10: an early fix blocks a second early one in the same period.
        run_case("R10", 1'b1, 1'b1, 29, 31, 9, 25, 40, 56, 29, 0);
        // R10: fixes in consecutive periods are both applied.
        run_case("R10", 1'b1, 1'b1, 29, 34, 9, 25, 40, 57, 29, 34);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule